// File: doc/BRIEF.md
# Coherent Angular-Rate Output Register Bank

This block keeps the most recent X and Y angular-rate samples (16-bit two's complement) and the latest die temperature, and serves them to a register-read port one byte at a time. The temperature arrives as a 12-bit two's-complement word, where zero means 25 °C. It is stored left-justified in a 16-bit pair. A fixed identity byte is also readable. Sample generation happens upstream. The block only captures, holds and presents the samples.

A software reader needs two byte reads for each 16-bit value. In hold mode the block makes sure the two bytes belong to the same sample. Once a value has been loaded into a pair, the pair stays frozen until both of its bytes have been read, in either order. A sample that arrives during the freeze is parked in a per-pair shadow register, and a newer arrival replaces the parked one. When the second byte read completes, the parked sample moves into the pair. In continuous mode every sample goes straight to its pair. A byte-order control picks whether the lower of the two addresses returns the low or the high byte.

Sample inputs are plain valid strobes and are always accepted; there is no back-pressure on them. Read requests are always accepted as well. Each request produces exactly one response, flagged by `rd_valid` one cycle later. The response cannot be stalled, so the requester must take it in that cycle.

Top module: `ois_out_regbank`

## Requirements
- R1: A read of address 00h returns DAh.
- R2: A read of any address above 06h returns 00h.
- R3: Every cycle with `rd_en` high is followed in the next cycle by `rd_valid` high, with the byte as it stood when the request was taken. `rd_valid` is low, and `rd_data` is 00h, one cycle after any cycle without a request.
- R4: The temperature pair sits at 01h/02h and holds `{temp_data, 4'b0000}`. With `cfg_msb_first`=0, 01h returns bits 7:0 and 02h returns bits 15:8.
- R5: With `cfg_msb_first`=0, the X pair at 03h/04h and the Y pair at 05h/06h return bits 7:0 at the lower address and bits 15:8 at the higher address.
- R6: With `cfg_msb_first`=1, the lower address of every pair returns bits 15:8 and the higher address returns bits 7:0.
- R7: With `cfg_cont_upd`=1, a sample strobed in one cycle is returned by a read issued in the following cycle, even while only one byte of the previous value has been read.
- R8: With `cfg_cont_upd`=0, after a pair is loaded its contents stay unchanged until both of its bytes have been read. Either order counts, and repeated reads of one byte do not count twice.
- R9: With `cfg_cont_upd`=0, the newest sample that arrived while a pair was frozen becomes readable in the cycle after the read that completes both bytes.
- R10: After reset all pairs read 0000h, `rd_valid` is low and `rd_data` is 00h.
- R11: Each pair is released only by reads of its own two addresses. Completing reads on one pair leaves another frozen pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cont_upd | input | 1 | 1: continuous update; 0: hold pair until both bytes read |
| cfg_msb_first | input | 1 | 1: high byte at lower address; 0: low byte at lower address |
| temp_vld | input | 1 | Temperature sample strobe |
| temp_data | input | 12 | Temperature sample, two's complement |
| x_vld | input | 1 | X-rate sample strobe |
| x_data | input | 16 | X-rate sample, two's complement |
| y_vld | input | 1 | Y-rate sample strobe |
| y_data | input | 16 | Y-rate sample, two's complement |
| rd_en | input | 1 | Read request |
| rd_addr | input | 7 | Read byte address |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |

## Verification
The identity register, unmapped addresses and the reset contents are read to separate address decode from storage. Hold mode is tried with three patterns: high byte first, repeated reads of a single byte, and several samples queued during one freeze. These show whether completion is tracked per byte and whether the newest parked sample wins. Two pairs are frozen together and only one of them is released, which shows that each pair's lock is independent. Byte order is then flipped, and continuous mode is run with a half-read pair, to show that swapping and freezing are decoupled.

// File: rtl/ois_regbank_pkg.sv
package ois_regbank_pkg;
  localparam int          NUM_CH     = 3;     // temperature, X, Y in address order
  localparam int          BYTE_W     = 8;
  localparam logic [6:0]  ADDR_ID    = 7'h00;
  localparam logic [6:0]  ADDR_FIRST = 7'h01; // first pair base; pairs follow every 2
  localparam logic [7:0]  ID_VALUE   = 8'hDA;
endpackage

// File: rtl/rate_pair_hold.sv
module rate_pair_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cont_i,
  input  logic              s_vld_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [DATA_W-1:0] pair_o,
  output logic              lock_o
);
  logic [DATA_W-1:0] pair_q, shad_q;
  logic              shad_vld_q, lock_q, lo_seen_q, hi_seen_q;
  logic              pair_done;

  assign pair_done = lock_q && (lo_seen_q || rd_lo_i) && (hi_seen_q || rd_hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q     <= '0;
      shad_q     <= '0;
      shad_vld_q <= 1'b0;
      lock_q     <= 1'b0;
      lo_seen_q  <= 1'b0;
      hi_seen_q  <= 1'b0;
    end else if (cont_i) begin
      if (s_vld_i)         pair_q <= s_data_i;
      else if (shad_vld_q) pair_q <= shad_q;
      shad_vld_q <= 1'b0;
      lock_q     <= 1'b0;
      lo_seen_q  <= 1'b0;
      hi_seen_q  <= 1'b0;
    end else if (!lock_q || pair_done) begin
      lo_seen_q <= 1'b0;
      hi_seen_q <= 1'b0;
      if (s_vld_i) begin
        pair_q     <= s_data_i;
        lock_q     <= 1'b1;
        shad_vld_q <= 1'b0;
      end else if (shad_vld_q) begin
        pair_q     <= shad_q;
        lock_q     <= 1'b1;
        shad_vld_q <= 1'b0;
      end else begin
        lock_q <= 1'b0;
      end
    end else begin
      if (rd_lo_i) lo_seen_q <= 1'b1;
      if (rd_hi_i) hi_seen_q <= 1'b1;
      if (s_vld_i) begin
        shad_q     <= s_data_i;
        shad_vld_q <= 1'b1;
      end
    end
  end

  assign pair_o = pair_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/regbank_read_mux.sv
module regbank_read_mux
  import ois_regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic                          msb_first_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] pairs_i,
  output logic [BYTE_W-1:0]             byte_o,
  output logic [NUM_CH-1:0]             rd_lo_o,
  output logic [NUM_CH-1:0]             rd_hi_o
);
  always_comb begin
    byte_o  = '0;
    rd_lo_o = '0;
    rd_hi_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_ID)) byte_o = ID_VALUE;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == ADDR_W'(int'(ADDR_FIRST) + 2*c) ||
          rd_addr_i == ADDR_W'(int'(ADDR_FIRST) + 2*c + 1)) begin
        // offset 0 is the lower address; byte order control flips it
        if ((rd_addr_i != ADDR_W'(int'(ADDR_FIRST) + 2*c)) ^ msb_first_i) begin
          byte_o     = pairs_i[c][DATA_W-1 -: BYTE_W];
          rd_hi_o[c] = rd_en_i;
        end else begin
          byte_o     = pairs_i[c][BYTE_W-1:0];
          rd_lo_o[c] = rd_en_i;
        end
      end
    end
  end
endmodule

// File: rtl/ois_out_regbank.sv
module ois_out_regbank
  import ois_regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cont_upd,
  input  logic              cfg_msb_first,
  input  logic              temp_vld,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic              x_vld,
  input  logic [DATA_W-1:0] x_data,
  input  logic              y_vld,
  input  logic [DATA_W-1:0] y_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - TEMP_W;

  logic [NUM_CH-1:0]             samp_vld;
  logic [NUM_CH-1:0][DATA_W-1:0] samp_data;
  logic [NUM_CH-1:0][DATA_W-1:0] pair_w;
  logic [NUM_CH-1:0]             lock_w, rd_lo_w, rd_hi_w;
  logic [BYTE_W-1:0]             byte_w;

  assign samp_vld  = {y_vld, x_vld, temp_vld};
  assign samp_data = {y_data, x_data, {temp_data, {PAD_W{1'b0}}}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
    rate_pair_hold #(.DATA_W(DATA_W)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .cont_i   (cfg_cont_upd),
      .s_vld_i  (samp_vld[c]),
      .s_data_i (samp_data[c]),
      .rd_lo_i  (rd_lo_w[c]),
      .rd_hi_i  (rd_hi_w[c]),
      .pair_o   (pair_w[c]),
      .lock_o   (lock_w[c])
    );
  end

  regbank_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .msb_first_i (cfg_msb_first),
    .pairs_i     (pair_w),
    .byte_o      (byte_w),
    .rd_lo_o     (rd_lo_w),
    .rd_hi_o     (rd_hi_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? byte_w : '0;
    end
  end
endmodule

// File: rtl/ois_out_regbank_chk.sv
module ois_out_regbank_chk
  import ois_regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_cont_upd,
  input logic                          x_vld,
  input logic [DATA_W-1:0]             x_data,
  input logic                          rd_en,
  input logic [ADDR_W-1:0]             rd_addr,
  input logic                          rd_valid,
  input logic [BYTE_W-1:0]             rd_data,
  input logic [NUM_CH-1:0][DATA_W-1:0] pair_w,
  input logic [NUM_CH-1:0]             lock_w
);
  AST_RD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R3
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0)); // R3
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(0)) |=> rd_data == ID_VALUE); // R1
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > ADDR_W'(6)) |=> rd_data == '0); // R2
  AST_CONT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cont_upd && x_vld) |=> pair_w[1] == $past(x_data)); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cont_upd && lock_w[1] && !rd_en) |=> $stable(pair_w[1])); // R8
endmodule

bind ois_out_regbank ois_out_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_cont_upd (cfg_cont_upd),
  .x_vld        (x_vld),
  .x_data       (x_data),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .pair_w       (pair_w),
  .lock_w       (lock_w)
);

// File: tb/ois_out_regbank_tb_top.sv
module ois_out_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cont_upd = 1'b0, cfg_msb_first = 1'b0;
  logic        temp_vld = 1'b0, x_vld = 1'b0, y_vld = 1'b0;
  logic [11:0] temp_data = '0;
  logic [15:0] x_data = '0, y_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ois_out_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cont_upd(cfg_cont_upd), .cfg_msb_first(cfg_msb_first),
    .temp_vld(temp_vld), .temp_data(temp_data), .x_vld(x_vld), .x_data(x_data),
    .y_vld(y_vld), .y_data(y_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: issue a read and push the expected response
  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    rd_en   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send(input int ch, input logic [15:0] v);
    @(negedge clk);
    case (ch)
      0: begin temp_vld = 1'b1; temp_data = v[11:0]; end
      1: begin x_vld = 1'b1; x_data = v; end
      default: begin y_vld = 1'b1; y_data = v; end
    endcase
    @(negedge clk);
    temp_vld = 1'b0; x_vld = 1'b0; y_vld = 1'b0;
  endtask

  // monitor: compare responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected response", int'(rd_data), 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0 && rd_data == 8'h00, "R10 reset outputs", int'(rd_data), 0);
    rd(7'h03, 8'h00, "R10 X low after reset");
    rd(7'h06, 8'h00, "R10 Y high after reset");
    @(negedge clk);
    check(rd_valid == 1'b0, "R3 idle rd_valid", int'(rd_valid), 0);

    rd(7'h00, 8'hDA, "R1 identity");
    rd(7'h07, 8'h00, "R2 addr 07h");
    rd(7'h0F, 8'h00, "R2 addr 0Fh");
    rd(7'h7F, 8'h00, "R2 addr 7Fh");

    send(1, 16'h1234);
    rd(7'h03, 8'h34, "R5 X low");
    rd(7'h04, 8'h12, "R5 X high");
    send(2, 16'hA5C3);
    rd(7'h05, 8'hC3, "R5 Y low");
    rd(7'h06, 8'hA5, "R5 Y high");
    send(0, 16'h09AB);
    rd(7'h01, 8'hB0, "R4 temp low");
    rd(7'h02, 8'h9A, "R4 temp high");

    send(1, 16'h1111);
    send(1, 16'h2222);
    rd(7'h04, 8'h11, "R8 frozen high first");
    send(1, 16'h3333);
    rd(7'h04, 8'h11, "R8 repeat same byte");
    rd(7'h03, 8'h11, "R8 completing low byte");
    rd(7'h03, 8'h33, "R9 newest parked low");
    rd(7'h04, 8'h33, "R9 newest parked high");

    send(1, 16'h4444);
    send(2, 16'h5555);
    send(2, 16'h6666);
    rd(7'h03, 8'h44, "R11 X low");
    rd(7'h04, 8'h44, "R11 X high");
    rd(7'h05, 8'h55, "R11 Y still frozen");
    rd(7'h06, 8'h55, "R11 Y high frozen");
    rd(7'h05, 8'h66, "R9 Y parked released");
    rd(7'h06, 8'h66, "R9 Y parked high");

    cfg_msb_first = 1'b1;
    send(1, 16'hBEEF);
    rd(7'h03, 8'hBE, "R6 X lower addr high byte");
    rd(7'h04, 8'hEF, "R6 X upper addr low byte");
    rd(7'h01, 8'h9A, "R6 temp swapped");
    rd(7'h02, 8'hB0, "R6 temp swapped upper");

    cfg_cont_upd = 1'b1;
    send(1, 16'h0102);
    rd(7'h03, 8'h01, "R7 continuous first");
    send(1, 16'h0304);
    rd(7'h04, 8'h04, "R7 update after half read");
    rd(7'h03, 8'h03, "R7 updated high");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 responses outstanding", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule